// File: doc/BRIEF.md
# Ping-Pong Line DMA Sequencer

This block drains packet data from an on-chip FIFO and writes it, one line at a time, into two destination buffers that take turns. A line is a whole number of packets: 20 packets of 188 bytes by default, 3760 bytes in all. The line moves as 8-byte beats over a simple write-request port. Each beat carries its byte address, the line length in 8-byte units, the data word, and start-of-line and end-of-line marks.

When run is enabled, the block first aligns to a packet boundary. It drops FIFO words until the head word starts with the sync byte. It then fills a fixed number of lines into buffer 0, then the same number into buffer 1, and loops back to buffer 0 without aligning again. Finishing a buffer sets that buffer's sticky interrupt status. Software sees the status through a mask and clears it by writing 1. A ready indication names the buffer to service, and buffer 0 wins when both are pending. Dropping run stops the transfer at the next line boundary. Raising run again starts over from the alignment step and from buffer 0, line 0.

Top module: `pingpong_line_dma`

## Requirements
- R1: The line length is PKT_BYTES*PKTS_PER_LINE bytes, 3760 by default. A length that is zero, not a multiple of 8, or above 4096 stops elaboration. Every accepted beat carries wr_len equal to the line length divided by 8.
- R2: A beat is accepted when wr_valid and wr_ready are both high. The accepted beat pops the FIFO head (fifo_rd high) and carries that word as wr_data. Its wr_addr is base + line*LINE_BYTES + beat*8, where base is base0 or base1 for the active buffer, line counts from 0 inside the buffer, and beat counts from 0 inside the line.
- R3: wr_sol is high on beat 0 of every line and wr_eol is high on the last beat of every line. Each line is a single request marked both as start and as end.
- R4: After alignment the order is LINES_PER_BUF lines to buffer 0, then LINES_PER_BUF lines to buffer 1, then back to buffer 0 line 0. The loop back does no alignment, so a head word without the sync byte is written and not dropped.
- R5: In the alignment step, each FIFO word whose low byte (bits 7:0) is not SYNC_BYTE (default 8'h47) is popped with no write. A head word whose low byte is SYNC_BYTE is not popped there and becomes beat 0 of line 0 in buffer 0.
- R6: The cycle after the last beat of the last line of buffer b is accepted, status bit b is set. Bit 0 drives irq_buf0 and bit 1 drives irq_buf1.
- R7: Status bits are sticky. A 1 on irq_clr[b] clears bit b on the next edge, but a set in the same cycle wins. irq_buf0/irq_buf1 equal the status bits ANDed with irq_mask[0]/irq_mask[1].
- R8: rdy_valid is high when either masked interrupt is pending. rdy_buf is 0 whenever masked bit 0 is pending, including when both are pending, and is 1 only when only masked bit 1 is pending.
- R9: With run_en low, a line already begun is finished, but no new line starts and no alignment word is dropped. Raising run_en restarts with alignment at buffer 0, line 0.
- R10: After reset the block is idle: wr_valid, fifo_rd, irq_buf0, irq_buf1 and rdy_valid are low, even with fifo_valid high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_en | input | 1 | Run enable |
| base0 | input | ADDR_W | Byte base address of buffer 0 |
| base1 | input | ADDR_W | Byte base address of buffer 1 |
| fifo_valid | input | 1 | FIFO head word present |
| fifo_data | input | 64 | FIFO head word, first byte in bits 7:0 |
| fifo_rd | output | 1 | Pop the FIFO head |
| wr_valid | output | 1 | Write beat offered |
| wr_ready | input | 1 | Write beat taken |
| wr_addr | output | ADDR_W | Byte address of the beat |
| wr_len | output | 10 | Line length in 8-byte units |
| wr_data | output | 64 | Beat data |
| wr_sol | output | 1 | First beat of a line |
| wr_eol | output | 1 | Last beat of a line |
| irq_mask | input | 2 | Interrupt enables, bit b for buffer b |
| irq_clr | input | 2 | Write-1 clear of status bit b |
| irq_buf0 | output | 1 | Buffer 0 complete interrupt |
| irq_buf1 | output | 1 | Buffer 1 complete interrupt |
| rdy_valid | output | 1 | A masked buffer interrupt is pending |
| rdy_buf | output | 1 | Buffer to service, 0 has priority |

## Verification
The bench drops run_en at random points, in the middle of a line and during alignment. A design that stopped mid-line would leave a line cut short, and one that ignored the drop would start a new line; both show up as a wr_valid mismatch. After each loop back it feeds non-sync head words. A design that aligned again on the wrap would pop them with no write instead of writing them into buffer 0. It also lets both completion bits pend at once and fires clears in the same cycle as a set. A wrong priority would name buffer 1, and clear-over-set would drop a completion.

// File: rtl/pp_dma_pkg.sv
package pp_dma_pkg;

  localparam int unsigned PP_BEAT_BYTES = 8;
  localparam int unsigned PP_MAX_LINE   = 4096;

  typedef enum logic [1:0] {
    PP_IDLE   = 2'd0,
    PP_RESYNC = 2'd1,
    PP_LINE   = 2'd2
  } pp_state_e;

  // byte offset of one beat inside a buffer
  function automatic logic [63:0] pp_beat_offset(input int unsigned line_idx,
                                                 input int unsigned beat_idx,
                                                 input int unsigned line_bytes);
    return 64'(line_idx) * 64'(line_bytes) + 64'(beat_idx) * 64'(PP_BEAT_BYTES);
  endfunction

  // line length in beats
  function automatic int unsigned pp_beats(input int unsigned line_bytes);
    return line_bytes / PP_BEAT_BYTES;
  endfunction

endpackage

// File: rtl/pp_seq_counters.sv
module pp_seq_counters #(
  parameter int unsigned BEATS  = 470,
  parameter int unsigned LINES  = 16,
  parameter int unsigned BEAT_W = 9,
  parameter int unsigned LINE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              step,
  output logic [BEAT_W-1:0] beat_o,
  output logic [LINE_W-1:0] line_o,
  output logic              buf_o,
  output logic              beat_first,
  output logic              beat_last,
  output logic [1:0]        done_o
);
  localparam logic [BEAT_W-1:0] BEAT_MAX = BEAT_W'(BEATS - 1);
  localparam logic [LINE_W-1:0] LINE_MAX = LINE_W'(LINES - 1);

  logic [BEAT_W-1:0] beat_q;
  logic [LINE_W-1:0] line_q;
  logic              buf_q;
  logic              line_last;

  assign beat_first = (beat_q == '0);
  assign beat_last  = (beat_q == BEAT_MAX);
  assign line_last  = (line_q == LINE_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_q <= '0;
      line_q <= '0;
      buf_q  <= 1'b0;
    end else if (clr) begin
      beat_q <= '0;
      line_q <= '0;
      buf_q  <= 1'b0;
    end else if (step) begin
      if (beat_last) begin
        beat_q <= '0;
        if (line_last) begin
          line_q <= '0;
          buf_q  <= ~buf_q;
        end else begin
          line_q <= line_q + 1'b1;
        end
      end else begin
        beat_q <= beat_q + 1'b1;
      end
    end
  end

  always_comb begin
    done_o = 2'b00;
    if (step && beat_last && line_last) done_o[buf_q] = 1'b1;
  end

  assign beat_o = beat_q;
  assign line_o = line_q;
  assign buf_o  = buf_q;
endmodule

// File: rtl/pp_irq_ctrl.sv
module pp_irq_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] set_i,
  input  logic [1:0] clr_i,
  input  logic [1:0] mask_i,
  output logic [1:0] stat_o,
  output logic [1:0] irq_o,
  output logic       rdy_valid_o,
  output logic       rdy_buf_o
);
  logic [1:0] stat_q;

  for (genvar b = 0; b < 2; b++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          stat_q[b] <= 1'b0;
      else if (set_i[b])   stat_q[b] <= 1'b1;
      else if (clr_i[b])   stat_q[b] <= 1'b0;
    end
    assign irq_o[b] = stat_q[b] & mask_i[b];
  end

  assign stat_o      = stat_q;
  assign rdy_valid_o = |irq_o;
  assign rdy_buf_o   = ~irq_o[0] & irq_o[1];
endmodule

// File: rtl/pingpong_line_dma.sv
module pingpong_line_dma
  import pp_dma_pkg::*;
#(
  parameter int unsigned ADDR_W        = 32,
  parameter int unsigned PKT_BYTES     = 188,
  parameter int unsigned PKTS_PER_LINE = 20,
  parameter int unsigned LINES_PER_BUF = 16,
  parameter logic [7:0]  SYNC_BYTE     = 8'h47
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_en,
  input  logic [ADDR_W-1:0] base0,
  input  logic [ADDR_W-1:0] base1,
  input  logic              fifo_valid,
  input  logic [63:0]       fifo_data,
  output logic              fifo_rd,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [9:0]        wr_len,
  output logic [63:0]       wr_data,
  output logic              wr_sol,
  output logic              wr_eol,
  input  logic [1:0]        irq_mask,
  input  logic [1:0]        irq_clr,
  output logic              irq_buf0,
  output logic              irq_buf1,
  output logic              rdy_valid,
  output logic              rdy_buf
);
  localparam int unsigned LINE_BYTES = PKT_BYTES * PKTS_PER_LINE;
  localparam int unsigned BEATS      = pp_beats(LINE_BYTES);
  localparam int unsigned BEAT_W     = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam int unsigned LINE_W     = (LINES_PER_BUF > 1) ? $clog2(LINES_PER_BUF) : 1;

  if (LINE_BYTES == 0 || LINE_BYTES % PP_BEAT_BYTES != 0 || LINE_BYTES > PP_MAX_LINE
      || LINES_PER_BUF == 0) begin : g_bad_line
    $error("pingpong_line_dma: line length must be a nonzero multiple of 8 up to 4096");
  end

  pp_state_e         st_q, st_d;
  logic [BEAT_W-1:0] beat;
  logic [LINE_W-1:0] line;
  logic              buf_sel;
  logic              beat_first, beat_last;
  logic [1:0]        done_evt;
  logic [1:0]        stat;
  logic [1:0]        irq_vec;
  logic              head_sync, line_go, resync_pop, beat_fire;
  logic              in_idle, in_resync;
  logic [ADDR_W-1:0] buf_base;
  logic [63:0]       offs;

  assign in_idle    = (st_q == PP_IDLE);
  assign in_resync  = (st_q == PP_RESYNC);
  assign head_sync  = (fifo_data[7:0] == SYNC_BYTE);
  assign line_go    = (st_q == PP_LINE) && (run_en || !beat_first);
  assign resync_pop = in_resync && run_en && fifo_valid && !head_sync;
  assign wr_valid   = line_go && fifo_valid;
  assign beat_fire  = wr_valid && wr_ready;
  assign fifo_rd    = beat_fire || resync_pop;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      PP_IDLE:   if (run_en) st_d = PP_RESYNC;
      PP_RESYNC: begin
        if (!run_en)                      st_d = PP_IDLE;
        else if (fifo_valid && head_sync) st_d = PP_LINE;
      end
      PP_LINE:   if (beat_first && !run_en) st_d = PP_IDLE;
      default:   st_d = PP_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= PP_IDLE;
    else        st_q <= st_d;
  end

  pp_seq_counters #(
    .BEATS (BEATS),
    .LINES (LINES_PER_BUF),
    .BEAT_W(BEAT_W),
    .LINE_W(LINE_W)
  ) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (in_idle),
    .step      (beat_fire),
    .beat_o    (beat),
    .line_o    (line),
    .buf_o     (buf_sel),
    .beat_first(beat_first),
    .beat_last (beat_last),
    .done_o    (done_evt)
  );

  pp_irq_ctrl u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_i      (done_evt),
    .clr_i      (irq_clr),
    .mask_i     (irq_mask),
    .stat_o     (stat),
    .irq_o      (irq_vec),
    .rdy_valid_o(rdy_valid),
    .rdy_buf_o  (rdy_buf)
  );

  assign buf_base = buf_sel ? base1 : base0;
  assign offs     = pp_beat_offset(32'(line), 32'(beat), LINE_BYTES);
  assign wr_addr  = buf_base + offs[ADDR_W-1:0];
  assign wr_len   = 10'(BEATS);
  assign wr_data  = fifo_data;
  assign wr_sol   = beat_first;
  assign wr_eol   = beat_last;
  assign irq_buf0 = irq_vec[0];
  assign irq_buf1 = irq_vec[1];
endmodule

// File: rtl/pp_dma_checker.sv
module pp_dma_checker #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned BEATS  = 470
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fifo_valid,
  input logic              fifo_rd,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic              wr_eol,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [9:0]        wr_len,
  input logic [1:0]        irq_clr,
  input logic [1:0]        done_evt,
  input logic [1:0]        stat,
  input logic              irq_buf0,
  input logic              rdy_valid,
  input logic              rdy_buf,
  input logic              in_idle,
  input logic              in_resync
);
  AST_RD_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd |-> fifo_valid); // R2
  AST_LEN_UNITS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> wr_len == 10'(BEATS)); // R1
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && !wr_eol) |=> (!wr_valid || wr_addr == $past(wr_addr) + ADDR_W'(8))); // R2
  AST_NO_WR_RESYNC: assert property (@(posedge clk) disable iff (!rst_n)
    in_resync |-> !wr_valid); // R5
  AST_DONE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt[0] |=> stat[0]); // R6
  AST_DONE_SETS_B1: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt[1] |=> stat[1]); // R6
  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (stat[0] && !irq_clr[0]) |=> stat[0]); // R7
  AST_PRIO_BUF0: assert property (@(posedge clk) disable iff (!rst_n)
    irq_buf0 |-> (rdy_valid && !rdy_buf)); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    in_idle |-> (!wr_valid && !fifo_rd)); // R9
endmodule

bind pingpong_line_dma pp_dma_checker #(
  .ADDR_W(ADDR_W),
  .BEATS (BEATS)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .fifo_valid(fifo_valid),
  .fifo_rd   (fifo_rd),
  .wr_valid  (wr_valid),
  .wr_ready  (wr_ready),
  .wr_eol    (wr_eol),
  .wr_addr   (wr_addr),
  .wr_len    (wr_len),
  .irq_clr   (irq_clr),
  .done_evt  (done_evt),
  .stat      (stat),
  .irq_buf0  (irq_buf0),
  .rdy_valid (rdy_valid),
  .rdy_buf   (rdy_buf),
  .in_idle   (in_idle),
  .in_resync (in_resync)
);

// File: tb/pingpong_line_dma_tb_top.sv
module pingpong_line_dma_tb_top;
  localparam int unsigned PKT   = 12;
  localparam int unsigned PPL   = 2;
  localparam int unsigned LINES = 4;
  localparam int unsigned LBYTES = PKT * PPL;     // 24 bytes
  localparam int unsigned NBEAT  = LBYTES / 8;    // 3 beats
  localparam logic [31:0] B0 = 32'h0010_0000;
  localparam logic [31:0] B1 = 32'h0020_0400;

  logic clk = 1'b0;
  always #2 clk = ~clk; // 250 MHz

  logic        rst_n = 1'b0;
  logic        run_en = 1'b0;
  logic        fifo_valid = 1'b0;
  logic [63:0] fifo_data = '0;
  logic        wr_ready = 1'b0;
  logic [1:0]  irq_mask = 2'b00;
  logic [1:0]  irq_clr = 2'b00;
  logic        fifo_rd, wr_valid, wr_sol, wr_eol, irq_buf0, irq_buf1, rdy_valid, rdy_buf;
  logic [31:0] wr_addr;
  logic [9:0]  wr_len;
  logic [63:0] wr_data;

  pingpong_line_dma #(
    .ADDR_W(32), .PKT_BYTES(PKT), .PKTS_PER_LINE(PPL), .LINES_PER_BUF(LINES), .SYNC_BYTE(8'h47)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .base0(B0), .base1(B1),
    .fifo_valid(fifo_valid), .fifo_data(fifo_data), .fifo_rd(fifo_rd),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_len(wr_len),
    .wr_data(wr_data), .wr_sol(wr_sol), .wr_eol(wr_eol),
    .irq_mask(irq_mask), .irq_clr(irq_clr), .irq_buf0(irq_buf0), .irq_buf1(irq_buf1),
    .rdy_valid(rdy_valid), .rdy_buf(rdy_buf)
  );

  int checks = 0;
  int errors = 0;
  bit done_flag = 0;

  // reference model state
  int m_st = 0; // 0 idle, 1 align, 2 line
  int m_beat = 0, m_line = 0, m_buf = 0;
  logic [1:0] exp_stat = 2'b00;
  logic [63:0] head;
  int sync_pct = 25;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [63:0] new_word();
    logic [63:0] w;
    w = {$urandom, $urandom};
    if (int'($urandom % 100) < sync_pct) w[7:0] = 8'h47;
    else if (w[7:0] == 8'h47) w[7:0] = 8'h48;
    return w;
  endfunction

  function automatic logic [31:0] exp_addr(input int b, input int ln, input int bt);
    return (b != 0 ? B1 : B0) + 32'(ln * LBYTES) + 32'(bt * 8);
  endfunction

  // one clock: drive at negedge, check combinational/registered outputs, advance model
  task automatic cycle(input bit run, input bit fv, input bit rdy, input logic [1:0] msk, input logic [1:0] clr);
    bit line_go, exp_wv, fire, disc;
    logic [1:0] set, mv;
    @(negedge clk);
    run_en = run; fifo_valid = fv; wr_ready = rdy; irq_mask = msk; irq_clr = clr;
    fifo_data = head;
    #1;
    line_go = (m_st == 2) && !(m_beat == 0 && !run);
    exp_wv  = line_go && fv;
    fire    = exp_wv && rdy;
    disc    = (m_st == 1) && run && fv && (head[7:0] != 8'h47);
    mv      = exp_stat & msk;
    chk(wr_valid == exp_wv, "R4 R9 wr_valid", 64'(wr_valid), 64'(exp_wv));
    chk(fifo_rd == (fire || disc), "R5 R2 fifo_rd", 64'(fifo_rd), 64'(fire || disc));
    chk({irq_buf1, irq_buf0} == mv, "R6 R7 irq", 64'({irq_buf1, irq_buf0}), 64'(mv));
    chk(rdy_valid == (|mv), "R8 rdy_valid", 64'(rdy_valid), 64'(|mv));
    chk(rdy_buf == (!mv[0] && mv[1]), "R8 rdy_buf", 64'(rdy_buf), 64'(!mv[0] && mv[1]));
    if (fire) begin
      chk(wr_addr == exp_addr(m_buf, m_line, m_beat), "R2 R4 wr_addr", 64'(wr_addr), 64'(exp_addr(m_buf, m_line, m_beat)));
      chk(wr_data == head, "R2 wr_data", wr_data, head);
      chk(wr_len == 10'(NBEAT), "R1 wr_len", 64'(wr_len), 64'(NBEAT));
      chk(wr_sol == (m_beat == 0), "R3 wr_sol", 64'(wr_sol), 64'(m_beat == 0));
      chk(wr_eol == (m_beat == NBEAT - 1), "R3 wr_eol", 64'(wr_eol), 64'(m_beat == NBEAT - 1));
    end
    set = 2'b00;
    case (m_st)
      0: if (run) begin m_st = 1; m_beat = 0; m_line = 0; m_buf = 0; end
      1: if (!run) m_st = 0;
         else if (fv && head[7:0] == 8'h47) m_st = 2;
      default: begin
        if (m_beat == 0 && !run) m_st = 0;
        else if (fire) begin
          if (m_beat == NBEAT - 1) begin
            m_beat = 0;
            if (m_line == LINES - 1) begin
              set[m_buf] = 1'b1;
              m_line = 0;
              m_buf = 1 - m_buf;
            end else m_line++;
          end else m_beat++;
        end
      end
    endcase
    exp_stat = (exp_stat & ~clr) | set;
    if (fire || disc) head = new_word();
  endtask

  initial begin
    #(4 * 150000);
    if (!done_flag) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit run;
    void'($urandom(32'd1234));
    head = new_word();
    // R10: reset state with data on offer
    fifo_valid = 1'b1; run_en = 1'b1; wr_ready = 1'b1; irq_mask = 2'b11;
    repeat (3) @(negedge clk);
    chk(!wr_valid && !fifo_rd, "R10 idle in reset", 64'({wr_valid, fifo_rd}), 64'(0));
    chk(!irq_buf0 && !irq_buf1 && !rdy_valid, "R10 irq in reset", 64'({irq_buf0, irq_buf1, rdy_valid}), 64'(0));
    run_en = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    cycle(1'b0, 1'b1, 1'b1, 2'b11, 2'b00);
    chk(!wr_valid && !fifo_rd, "R10 idle after reset", 64'({wr_valid, fifo_rd}), 64'(0));

    // R4/R5 directed: start with non-sync words, full flow, both pending
    sync_pct = 0;
    head = new_word();
    cycle(1'b1, 1'b1, 1'b1, 2'b11, 2'b00);
    repeat (5) cycle(1'b1, 1'b1, 1'b1, 2'b11, 2'b00); // drops, R5
    sync_pct = 100;
    head = new_word();
    sync_pct = 0; // after alignment, loop back must not realign (R4)
    for (int i = 0; i < 2 * LINES * NBEAT + 4; i++) cycle(1'b1, 1'b1, 1'b1, 2'b11, 2'b00);
    chk(rdy_valid && !rdy_buf && irq_buf0 && irq_buf1, "R8 both pending picks buffer 0",
        64'({rdy_valid, rdy_buf, irq_buf0, irq_buf1}), 64'(4'b1011));
    cycle(1'b1, 1'b1, 1'b1, 2'b11, 2'b01);
    cycle(1'b1, 1'b1, 1'b1, 2'b11, 2'b00);
    chk(rdy_valid && rdy_buf, "R8 only buffer 1 pending", 64'({rdy_valid, rdy_buf}), 64'(2'b11));
    cycle(1'b1, 1'b1, 1'b1, 2'b01, 2'b00);
    chk(!rdy_valid && !irq_buf1, "R7 masked bit hidden", 64'({rdy_valid, irq_buf1}), 64'(0));
    cycle(1'b1, 1'b1, 1'b1, 2'b11, 2'b11);

    // R9 directed: drop run mid-line
    for (int i = 0; i < NBEAT + 1; i++) cycle(1'b1, 1'b1, 1'b1, 2'b11, 2'b00);
    for (int i = 0; i < 8; i++) cycle(1'b0, 1'b1, 1'b1, 2'b11, 2'b00);
    chk(!wr_valid, "R9 stopped at boundary", 64'(wr_valid), 64'(0));

    // constrained random
    sync_pct = 20;
    run = 1'b1;
    for (int i = 0; i < 6000; i++) begin
      logic [1:0] clr;
      if (($urandom % 100) < 2) run = ~run;
      clr = (($urandom % 100) < 10) ? 2'($urandom) : 2'b00;
      cycle(run, ($urandom % 100) < 75, ($urandom % 100) < 70, 2'($urandom | 1), clr);
    end
    done_flag = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule